// File: doc/BRIEF.md
# Systolic Matrix-Vector Multiplier

The block forms c = A·b for a square matrix A and a vector b on a linear chain of identical multiply-accumulate cells, four of them by default. Cell j keeps the vector element b(j) in a local register. A running partial sum enters the chain at cell 0 as zero. Each cell adds the product of its matrix entry and its resident coefficient, then registers the sum for the next cell. The sum that leaves the last cell is the finished dot product c(i) of matrix row i with b.

The vector is written one element per cycle through a small load port. Matrix rows are then streamed with a single valid flag. The caller applies the skew: when the valid flag marks row i, lane 0 of the matrix word carries A(i,0), and lane j carries A(i,j) exactly j cycles later. One new row can enter every cycle. All arithmetic is signed two's complement with 16-bit operands and a 34-bit accumulator, and nothing saturates.

Top module: `mv_systolic`

## Requirements
- R1: After reset, res_valid is 0, res_data is 0 and every resident coefficient is 0. A row streamed before any vector load therefore yields 0.
- R2: When vec_load is 1, the array is idle and vec_idx = j, the cell j coefficient takes vec_data at the clock edge. At most one cell is written per cycle.
- R3: For each streamed row i, res_data equals the sum over j of A(i,j)·b(j), computed signed at 34 bits.
- R4: Lane j (mat_data bits [16j+15:16j]) is used only in the cycle j cycles after a cycle in which mat_valid was 1. In every other cycle its value has no effect on any result.
- R5: A row whose mat_valid is sampled at clock edge e is output with res_valid = 1 after edge e+DIM-1, which is the edge that samples its last entry.
- R6: Rows may be presented on consecutive cycles, and each one yields its own correct result on consecutive cycles.
- R7: While res_valid is 0, res_data is 0.
- R8: A vector load is ignored while mat_valid is 1 or any row is still in the chain. Coefficients do not change during that time.
- R9: Idle cycles between rows produce no res_valid pulse and do not disturb later results.
- R10: Full-scale operands (-32768 for every entry and coefficient) give the exact result 2^32 with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_load | input | 1 | Write one vector element |
| vec_idx | input | 2 | Index of the cell to write |
| vec_data | input | 16 | Signed vector element |
| mat_valid | input | 1 | Marks the first entry of a row on lane 0 |
| mat_data | input | 64 | Skewed matrix entries, one 16-bit signed lane per cell |
| res_valid | output | 1 | res_data holds a finished c(i) |
| res_data | output | 34 | Signed dot-product result |

## Verification
Small mixed-sign matrices separate correct column-to-cell pairing from transposed or mis-skewed indexing. Full-scale negative operands expose a narrow or unsigned product path. Back-to-back rows, rows with idle gaps and rows surrounded by nonzero junk on unused lanes distinguish proper valid tracking from sampling lanes at the wrong cycle. A vector write attempted mid-stream, followed by a run with no reload, shows whether the busy interlock protects the coefficients. A row streamed straight after reset shows that the coefficients start at zero.

// File: rtl/mv_pkg.sv
package mv_pkg;
    localparam int DEF_DIM    = 4;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_ACC_W  = 34;
endpackage

// File: rtl/mv_pe.sv
module mv_pe #(
    parameter int DATA_W = mv_pkg::DEF_DATA_W,
    parameter int ACC_W  = mv_pkg::DEF_ACC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_en,
    input  logic signed [DATA_W-1:0] load_data,
    input  logic                     in_vld,
    input  logic signed [ACC_W-1:0]  in_sum,
    input  logic signed [DATA_W-1:0] a_in,
    output logic                     out_vld,
    output logic signed [ACC_W-1:0]  out_sum,
    output logic signed [DATA_W-1:0] coef
);
    localparam int PROD_W = 2 * DATA_W;

    typedef struct packed {
        logic                     vld;
        logic signed [ACC_W-1:0]  sum;
        logic signed [DATA_W-1:0] coef;
    } pe_state_t;

    pe_state_t st_d, st_q;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        st_d = st_q;
        prod = a_in * st_q.coef;
        if (load_en) begin
            st_d.coef = load_data;
        end
        st_d.vld = in_vld;
        st_d.sum = in_vld ? (in_sum + ACC_W'(prod)) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign out_sum = st_q.sum;
    assign coef    = st_q.coef;
endmodule

// File: rtl/mv_load_dec.sv
module mv_load_dec #(
    parameter int DIM   = mv_pkg::DEF_DIM,
    parameter int IDX_W = $clog2(DIM)
) (
    input  logic             vec_load,
    input  logic [IDX_W-1:0] vec_idx,
    input  logic             busy,
    output logic [DIM-1:0]   load_en
);
    for (genvar g = 0; g < DIM; g++) begin : g_en
        assign load_en[g] = vec_load && !busy && (vec_idx == IDX_W'(g));
    end
endmodule

// File: rtl/mv_systolic.sv
module mv_systolic #(
    parameter int DIM    = mv_pkg::DEF_DIM,
    parameter int DATA_W = mv_pkg::DEF_DATA_W,
    parameter int ACC_W  = mv_pkg::DEF_ACC_W,
    localparam int IDX_W = $clog2(DIM),
    localparam int MAT_W = DIM * DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vec_load,
    input  logic [IDX_W-1:0]         vec_idx,
    input  logic signed [DATA_W-1:0] vec_data,
    input  logic                     mat_valid,
    input  logic [MAT_W-1:0]         mat_data,
    output logic                     res_valid,
    output logic signed [ACC_W-1:0]  res_data
);
    logic                    chain_vld [DIM+1];
    logic signed [ACC_W-1:0] chain_sum [DIM+1];
    logic [DIM-1:0]          load_en;
    logic [DIM-1:0]          vld_vec;
    logic [MAT_W-1:0]        coef_all;
    logic                    busy;

    assign chain_vld[0] = mat_valid;
    assign chain_sum[0] = '0;
    assign busy = mat_valid || (|vld_vec);

    mv_load_dec #(.DIM(DIM), .IDX_W(IDX_W)) u_dec (
        .vec_load (vec_load),
        .vec_idx  (vec_idx),
        .busy     (busy),
        .load_en  (load_en)
    );

    for (genvar g = 0; g < DIM; g++) begin : g_pe
        mv_pe #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_pe (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_en   (load_en[g]),
            .load_data (vec_data),
            .in_vld    (chain_vld[g]),
            .in_sum    (chain_sum[g]),
            .a_in      (mat_data[g*DATA_W +: DATA_W]),
            .out_vld   (chain_vld[g+1]),
            .out_sum   (chain_sum[g+1]),
            .coef      (coef_all[g*DATA_W +: DATA_W])
        );
        assign vld_vec[g] = chain_vld[g+1];
    end

    assign res_valid = chain_vld[DIM];
    assign res_data  = chain_sum[DIM];
endmodule

// File: rtl/mv_systolic_chk.sv
module mv_systolic_chk #(
    parameter int DIM    = mv_pkg::DEF_DIM,
    parameter int DATA_W = mv_pkg::DEF_DATA_W,
    parameter int ACC_W  = mv_pkg::DEF_ACC_W
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   mat_valid,
    input logic                   res_valid,
    input logic [ACC_W-1:0]       res_data,
    input logic [DIM-1:0]         load_en,
    input logic                   busy,
    input logic [DIM*DATA_W-1:0]  coef_all
);
    logic [DIM-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[DIM-2:0], mat_valid};
        end
    end

    // R5
    latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == hist_q[DIM-1]);

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_data == '0));

    // R2
    single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_en));

    // R8
    busy_noload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (load_en == '0));

    // R8
    coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(coef_all));
endmodule

bind mv_systolic mv_systolic_chk #(.DIM(DIM), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mat_valid (mat_valid),
    .res_valid (res_valid),
    .res_data  (res_data),
    .load_en   (load_en),
    .busy      (busy),
    .coef_all  (coef_all)
);

// File: tb/sim_mv_systolic.sv
module sim_mv_systolic;
    localparam int DIM = 4;
    localparam int DW  = 16;
    localparam int AW  = 34;
    localparam int NCASE = 3;

    // per case: b[0..3], then A row-major (16 entries)
    localparam logic signed [DW-1:0] TBL [NCASE][20] = '{
        '{16'sd1, 16'sd2, 16'sd3, 16'sd4,
          16'sd1, 16'sd0, 16'sd0, 16'sd0,
          16'sd0, 16'sd1, 16'sd0, 16'sd0,
          16'sd5, 16'sd6, 16'sd7, 16'sd8,
          16'sd10, 16'sd20, 16'sd30, 16'sd40},
        '{-16'sd3, 16'sd7, -16'sd11, 16'sd250,
          -16'sd100, 16'sd200, -16'sd300, 16'sd400,
          16'sd1234, -16'sd4321, 16'sd99, -16'sd1,
          16'sd32767, 16'sd32767, 16'sd32767, 16'sd32767,
          -16'sd2, -16'sd2, -16'sd2, -16'sd2},
        '{-16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768,
          -16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768,
          16'sd32767, 16'sd32767, 16'sd32767, 16'sd32767,
          16'sd32767, -16'sd32768, 16'sd32767, -16'sd32768,
          16'sd0, 16'sd0, 16'sd0, 16'sd1}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic vec_load = 0;
    logic [1:0] vec_idx = '0;
    logic signed [DW-1:0] vec_data = '0;
    logic mat_valid = 0;
    logic [DIM*DW-1:0] mat_data = '0;
    logic res_valid;
    logic signed [AW-1:0] res_data;

    mv_systolic u0 (
        .clk(clk), .rst_n(rst_n), .vec_load(vec_load), .vec_idx(vec_idx),
        .vec_data(vec_data), .mat_valid(mat_valid), .mat_data(mat_data),
        .res_valid(res_valid), .res_data(res_data)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_exp = 0;
    int n_got = 0;
    int idle_bad = 0;
    string cur_tag = "R3";
    logic signed [DW-1:0] vec_b [DIM];
    logic signed [DW-1:0] mat_a [16][DIM];
    longint exp_val [64];
    int     exp_cyc [64];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid) begin
                if (n_got >= n_exp) begin
                    check(0, cur_tag, longint'(res_data), -1);
                end else begin
                    check(longint'(res_data) == exp_val[n_got], cur_tag,
                          longint'(res_data), exp_val[n_got]);
                    check(cyc == exp_cyc[n_got] + DIM, "R5", cyc, exp_cyc[n_got] + DIM);
                end
                n_got++;
            end else if (res_data != '0) begin
                idle_bad++;
            end
        end
    end

    function automatic longint dot(input int r);
        longint acc = 0;
        for (int j = 0; j < DIM; j++) acc += longint'(mat_a[r][j]) * longint'(vec_b[j]);
        return acc;
    endfunction

    task automatic load_vec(input logic signed [DW-1:0] b [DIM]);
        for (int j = 0; j < DIM; j++) begin
            @(negedge clk);
            vec_load = 1; vec_idx = 2'(j); vec_data = b[j];
            vec_b[j] = b[j];
        end
        @(negedge clk);
        vec_load = 0;
    endtask

    task automatic run_rows(input int nrows, input int gap, input bit poke,
                            input logic signed [DW-1:0] junk);
        int per = gap + 1;
        int len = (nrows - 1) * per + DIM;
        n_exp = 0; n_got = 0;
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            mat_valid = (c % per == 0) && (c / per < nrows);
            if (mat_valid) begin
                exp_val[n_exp] = dot(c / per);
                exp_cyc[n_exp] = cyc;
                n_exp++;
            end
            for (int j = 0; j < DIM; j++) begin
                int cc = c - j;
                if (cc >= 0 && cc % per == 0 && cc / per < nrows)
                    mat_data[j*DW +: DW] = mat_a[cc / per][j];
                else
                    mat_data[j*DW +: DW] = junk ^ DW'(c);
            end
            vec_load = poke && (c == 1);
            vec_idx  = 2'd1;
            vec_data = 16'sh1234;
        end
        @(negedge clk);
        mat_valid = 0; vec_load = 0; mat_data = {DIM{junk}};
        repeat (DIM + 1) @(negedge clk);
        check(n_got == n_exp, cur_tag, n_got, n_exp);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic signed [DW-1:0] bt [DIM];
        for (int j = 0; j < DIM; j++) vec_b[j] = '0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during and right after reset
        check(res_valid == 0, "R1", res_valid, 0);
        check(res_data == 0, "R1", res_data, 0);
        rst_n = 1;
        @(negedge clk);
        check(res_valid == 0, "R1", res_valid, 0);
        // R1: no vector loaded yet, so result must be zero
        cur_tag = "R1";
        for (int j = 0; j < DIM; j++) mat_a[0][j] = DW'(j * 111 + 7);
        run_rows(1, 0, 0, 16'sh0F0F);

        // table walk: R2 load, R3 values, R10 full scale case
        for (int k = 0; k < NCASE; k++) begin
            for (int j = 0; j < DIM; j++) bt[j] = TBL[k][j];
            for (int r = 0; r < DIM; r++)
                for (int j = 0; j < DIM; j++) mat_a[r][j] = TBL[k][4 + r*DIM + j];
            load_vec(bt);
            cur_tag = (k == 2) ? "R10" : "R3";
            run_rows(DIM, 0, 0, 16'sh5A5A);
        end
        check(dot(0) == 64'sd4294967296, "R10", dot(0), 64'sd4294967296);

        // R2: reload with new values, results follow the new vector
        bt = '{16'sd9, -16'sd8, 16'sd7, -16'sd6};
        load_vec(bt);
        for (int r = 0; r < DIM; r++)
            for (int j = 0; j < DIM; j++) mat_a[r][j] = DW'(r * 13 - j * 5 + 1);
        cur_tag = "R2";
        run_rows(DIM, 0, 0, 16'sh1111);

        // R6: long back-to-back stream
        for (int r = 0; r < 12; r++)
            for (int j = 0; j < DIM; j++) mat_a[r][j] = DW'(r * 97 - j * 301 - 500);
        cur_tag = "R6";
        run_rows(12, 0, 0, 16'sh2222);

        // R9: idle gaps between rows
        cur_tag = "R9";
        run_rows(5, 2, 0, 16'sh3333);

        // R4: extreme junk on lanes outside their slot
        cur_tag = "R4";
        run_rows(2, 3, 0, -16'sh8000);

        // R8: load attempt while busy is ignored (model keeps old vector)
        cur_tag = "R8";
        run_rows(4, 0, 1, 16'sh4444);
        run_rows(3, 1, 0, 16'sh4444);

        // R7: no nonzero data seen while idle
        check(idle_bad == 0, "R7", idle_bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule